// File: doc/BRIEF.md
# Synchronized Glitch-Free Clock Stop Gate

This block gates a group of clock outputs that share one free-running source clock. An active-low, asynchronous stop request passes through a synchronizer clocked by that source. The output group then stops or restarts after a fixed, bounded number of source cycles. A stopped output is parked at logic 0. Every high phase that leaves the block is a complete copy of the source high phase, so no runt pulse appears on either transition.

Each output has an enable bit. An output whose bit is clear stays low whatever the stop input does. After a restart, the group must run for a minimum number of cycles before a new stop is honoured. A stop request that arrives earlier is held back until that count completes, and a flag output reports every cycle of such a deferral. One instance serves a fast processor clock group (two synchronizer stages, 100-cycle minimum run). A second instance serves a bus clock group (one stage, 10-cycle minimum run). Free-running clocks never pass through this block.

Top module: `clk_stop_gate`

## Requirements
- R1: While rst_ni is low, every gclk_o bit and defer_o are 0. After reset is released with stop_ni high, enabled outputs carry full pulses from the second source rising edge after release, and the minimum-run interval counts as already met.
- R2: While the synchronized stop request is in effect, every gclk_o bit is held at 0.
- R3: If E1 is the first rising edge at which stop_ni is sampled low, full pulses continue at E1 through E(SYNC_STAGES). Outputs are low from E(SYNC_STAGES+1) on. With the default of 2 stages, that is the third edge.
- R4: If E1 is the first rising edge at which stop_ni is sampled high again, the outputs stay low through E(SYNC_STAGES). The first pulse is at E(SYNC_STAGES+1) and has a full high phase.
- R5: No gclk_o bit is ever high while clk_i is low. Each high phase of an enabled, running output lasts the whole source high phase.
- R6: Let P1 be the first pulse edge after a restart. A stop request is not honoured before MIN_RUN more edges have been counted. For a request seen at P1+1, pulses continue through P1+MIN_RUN and the outputs are low from P1+MIN_RUN+1.
- R7: defer_o is 1 in exactly those cycles in which the synchronized stop request is pending but held back by the minimum-run count. At all other times it is 0.
- R8: If bit k of en_mask_i is 0, gclk_o[k] stays 0. Other bits are not affected. The mask is taken at the source falling edge, so a change takes effect at the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running source clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| stop_ni | input | 1 | Asynchronous active-low stop request |
| en_mask_i | input | NUM_OUT | Per-output enable, 1 = output may run |
| gclk_o | output | NUM_OUT | Gated clock outputs |
| defer_o | output | 1 | Stop request held back by the minimum-run count |

## Verification
The assertions assume two things about the inputs. First, stop_ni holds each level for at least SYNC_STAGES+1 source cycles. Second, en_mask_i never changes close to a source falling edge. The stimulus meets both conditions by driving stop_ni and the mask 2 ns after a rising edge and keeping every stop or run phase longer than the synchronizer depth. Within these limits, the checks of output latency, minimum run and deferral cycles rest on a fixed number of edges. That edge count is worked out from SYNC_STAGES and MIN_RUN alone.

// File: rtl/clk_stop_pkg.sv
package clk_stop_pkg;
  // counter width able to hold 0..limit
  function automatic int unsigned cnt_bits(input int unsigned limit);
    return (limit == 0) ? 1 : $clog2(limit + 1);
  endfunction
endpackage

// File: rtl/clk_stop_sync.sv
module clk_stop_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_ni,
  output logic req_o
);
  logic [STAGES-1:0] q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '1;
        else         q <= async_ni;
      end
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '1;
        else         q <= {q[STAGES-2:0], async_ni};
      end
    end
  endgenerate

  assign req_o = ~q[STAGES-1];
endmodule

// File: rtl/clk_stop_guard.sv
module clk_stop_guard
  import clk_stop_pkg::*;
#(
  parameter int unsigned MIN_RUN = 100
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic stop_req_i,
  output logic run_o,
  output logic defer_o
);
  localparam int unsigned CW = cnt_bits(MIN_RUN);
  localparam logic [CW-1:0] RUN_MAX = CW'(MIN_RUN);

  logic          run_q, run_d, done;
  logic [CW-1:0] cnt_q;

  assign done = (cnt_q == RUN_MAX);

  always_comb begin
    if (!stop_req_i)  run_d = 1'b1;
    else if (run_q)   run_d = ~done;
    else              run_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b1;
      cnt_q <= RUN_MAX;  // reset counts as a completed run
    end else begin
      run_q <= run_d;
      if (!run_q)      cnt_q <= '0;
      else if (!done)  cnt_q <= cnt_q + 1'b1;
    end
  end

  // gate cells sample this on the falling edge
  assign run_o   = run_d;
  assign defer_o = run_q & stop_req_i & ~done;

  assert_min_run_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(run_q) |-> $past(cnt_q) == RUN_MAX);
  assert_stay_stopped_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_q && stop_req_i) |=> !run_q);
  assert_restart_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stop_req_i |=> run_q);
  assert_stop_due_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_req_i && cnt_q == RUN_MAX) |=> !run_q);
  assert_defer_runs_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    defer_o |=> run_q);
endmodule

// File: rtl/clk_gate_cell.sv
module clk_gate_cell (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic mask_i,
  output logic gclk_o
);
  logic en_q;

  // enable moves only while the source is low
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_q <= 1'b0;
    else         en_q <= run_i & mask_i;
  end

  assign gclk_o = clk_i & en_q;

  assert_mask_low_R8: assert property (@(negedge clk_i) disable iff (!rst_ni)
    !mask_i |=> !en_q);
  assert_stop_low_R2: assert property (@(negedge clk_i) disable iff (!rst_ni)
    !run_i |=> !en_q);
endmodule

// File: rtl/clk_stop_gate.sv
module clk_stop_gate #(
  parameter int unsigned NUM_OUT     = 4,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned MIN_RUN     = 100
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               stop_ni,
  input  logic [NUM_OUT-1:0] en_mask_i,
  output logic [NUM_OUT-1:0] gclk_o,
  output logic               defer_o
);
  logic stop_req, run;

  clk_stop_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .async_ni (stop_ni),
    .req_o    (stop_req)
  );

  clk_stop_guard #(.MIN_RUN(MIN_RUN)) u_guard (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .stop_req_i (stop_req),
    .run_o      (run),
    .defer_o    (defer_o)
  );

  generate
    for (genvar k = 0; k < NUM_OUT; k++) begin : g_cell
      clk_gate_cell u_cell (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .run_i  (run),
        .mask_i (en_mask_i[k]),
        .gclk_o (gclk_o[k])
      );
    end
  endgenerate

  assert_reset_quiet_R1: assert property (@(posedge clk_i)
    !rst_ni |-> (gclk_o == '0 && !defer_o));
endmodule

// File: tb/clk_stop_gate_tb_top.sv
module clk_stop_gate_tb_top;
  localparam int N  = 3;
  localparam int S  = 2;
  localparam int MR = 6;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         stop_n = 1'b1;
  logic [N-1:0] mask = '1;
  logic [N-1:0] gclk;
  logic         defer;
  logic         nxt_stop = 1'b1;
  logic [N-1:0] nxt_mask = '1;
  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  clk_stop_gate #(.NUM_OUT(N), .SYNC_STAGES(S), .MIN_RUN(MR)) dut_i (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .stop_ni   (stop_n),
    .en_mask_i (mask),
    .gclk_o    (gclk),
    .defer_o   (defer)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s at %0t: actual=%0h expected=%0h", req, $time, act, exp);
    end
  endtask

  // one source cycle: drive at +2, check high phase at +5, low phase at +15
  task automatic step(input logic [N-1:0] exp_clk, input logic exp_def, input string req);
    @(posedge clk);
    #2;
    stop_n = nxt_stop;
    mask   = nxt_mask;
    #3;
    check(req, 8'(gclk), 8'(exp_clk));
    check("R7 defer", 8'(defer), 8'(exp_def));
    #10;
    check("R5 low phase", 8'(gclk), 8'h00);
  endtask

  // stop from a saturated run, hold for hold edges, restart and resaturate
  task automatic stop_cycle(input int hold, input logic [N-1:0] m);
    nxt_stop = 1'b0;
    step(m, 1'b0, "R3 edge of drive");
    for (int i = 1; i <= S; i++) step(m, 1'b0, "R3 pulses before stop");
    for (int i = S + 1; i <= hold; i++) begin
      if (i == hold) nxt_stop = 1'b1;
      step('0, 1'b0, "R2 held low");
    end
    for (int j = 1; j <= S; j++) step('0, 1'b0, "R4 still low");
    step(m, 1'b0, "R4 first pulse");
    for (int j = 0; j <= MR; j++) step(m, 1'b0, "R6 run");
  endtask

  initial begin
    #(20 * 200000);
    total++;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [N-1:0] cur;
    repeat (3) @(posedge clk);
    #5;
    check("R1 reset gclk", 8'(gclk), 8'h00);
    check("R1 reset defer", 8'(defer), 8'h00);
    #10;
    rst_n = 1'b1;
    step('0, 1'b0, "R1 first edge");
    for (int i = 0; i < MR + 3; i++) step('1, 1'b0, "R1 running");

    // R8 mask sweep
    cur = '1;
    for (int m = 0; m < (1 << N); m++) begin
      nxt_mask = N'(m);
      step(cur, 1'b0, "R8 old mask");
      cur = N'(m);
      step(cur, 1'b0, "R8 new mask");
      step(cur, 1'b0, "R8 new mask");
    end
    nxt_mask = '1;
    step(cur, 1'b0, "R8 old mask");
    step('1, 1'b0, "R8 restore");

    // R3/R4/R2 sweep over stop lengths
    for (int h = S + 1; h <= S + 6; h++) stop_cycle(h, '1);
    nxt_mask = 3'b101;
    step('1, 1'b0, "R8 old mask");
    stop_cycle(S + 1, 3'b101);
    stop_cycle(S + 4, 3'b101);
    nxt_mask = '1;
    step(3'b101, 1'b0, "R8 old mask");

    // R6/R7 deferred stop right after a restart
    nxt_stop = 1'b0;
    step('1, 1'b0, "R3 edge of drive");
    for (int i = 1; i <= S; i++) step('1, 1'b0, "R3 pulses");
    nxt_stop = 1'b1;
    step('0, 1'b0, "R2 low");
    for (int j = 1; j <= S; j++) step('0, 1'b0, "R4 still low");
    nxt_stop = 1'b0;
    step('1, 1'b0, "R4 first pulse P1");
    for (int k = 1; k < S; k++) step('1, 1'b0, "R6 before sync");
    for (int k = S; k < MR; k++) step('1, 1'b1, "R6 deferred pulse");
    step('1, 1'b0, "R6 last pulse");
    step('0, 1'b0, "R6 stopped");
    nxt_stop = 1'b1;
    step('0, 1'b0, "R2 low");
    for (int j = 1; j <= S; j++) step('0, 1'b0, "R4 still low");
    for (int j = 0; j <= MR + 1; j++) step('1, 1'b0, "R4 running");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule